// File: doc/BRIEF.md
# Filtered Quadrature Decoder with x1/x2/x4 Resolution

This block turns two encoder phase signals into one-clock up and down count strobes. A downstream counter consumes the strobes. In quadrature operation both phases first pass through a two-flop synchroniser. A stability filter then accepts a new level on a phase only after it has held for a programmable number of clocks. The filtered pair is decoded as a two-bit Gray sequence and produces 4, 2 or 1 counts per encoder cycle.

With quadrature decoding switched off, the inputs act as counting clocks, and the filter is bypassed. The two inputs are either an up clock and a down clock, or a clock plus a direction level. A direction flag follows the last quadrature count. It reads 1 whenever quadrature decoding is off. An active-low gate suppresses all strobes. Motion seen while the gate is low is tracked, so it is never counted later.

Top module: `qdec_top`

## Requirements
- R1: While reset is held, and until counting starts, `up_stb` and `dn_stb` are 0 and `dir_up` is 1.
- R2: With `mode`=2'b11 (x4), every single-phase step of the filtered {B,A} pair makes one strobe. The forward order 00→01→11→10→00 gives `up_stb` and the reverse order gives `dn_stb`.
- R3: With `mode`=2'b10 (x2), only steps in which A changes make a strobe. Steps in which B changes make none.
- R4: With `mode`=2'b01 (x1), only the step between {B,A}=00 and 01 counts. 00→01 gives up and 01→00 gives down. All other steps make no strobe.
- R5: In any quadrature mode, a step in which both phases change at once makes no strobe and leaves `dir_up` unchanged.
- R6: In quadrature mode, a phase change is accepted only after the synchronised input has differed from the accepted level for FILT_CYCLES consecutive clocks. A shorter excursion is ignored.
- R7: A quadrature strobe is high during the clock that follows the (FILT_CYCLES+3)th rising edge after an input change. In non-quadrature mode the strobe follows the 3rd rising edge.
- R8: In quadrature mode, `dir_up` becomes 1 with each up strobe and 0 with each down strobe, and holds its value otherwise.
- R9: With `mode`=2'b00, `dir_up` reads 1.
- R10: With `mode`=2'b00 and `b_is_dir`=0, a rising edge of A gives `up_stb` and a rising edge of B gives `dn_stb`.
- R11: With `mode`=2'b00 and `b_is_dir`=1, a rising edge of A gives `up_stb` when B=0 and `dn_stb` when B=1. A change of B alone gives nothing.
- R12: While `gate_n`=0 no strobe is issued. Steps taken while gated are not counted after the gate opens.
- R13: `up_stb` and `dn_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 off, 01 x1, 10 x2, 11 x4 |
| b_is_dir | input | 1 | Non-quadrature: 1 makes B a direction level, 0 a down clock |
| gate_n | input | 1 | Active-low count gate |
| enc_a | input | 1 | Phase A / up clock |
| enc_b | input | 1 | Phase B / down clock / direction |
| up_stb | output | 1 | One-clock up count strobe |
| dn_stb | output | 1 | One-clock down count strobe |
| dir_up | output | 1 | Direction flag, 1 = up |

## Verification
The filter acceptance boundary is the hardest behaviour to reach from the ports. A phase excursion one clock too short must vanish, and one of exactly FILT_CYCLES clocks must count both ways. The stimulus gets there by driving each excursion from a falling clock edge and holding it for a counted number of clocks. The bench also counts the clocks up to the strobe, to pin the latency through synchroniser, filter and decoder registers. The x1/x2 masking and the illegal double-phase jump are reached by a table that walks the encoder through every step kind from known settled states.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    QM_OFF = 2'b00,
    QM_X1  = 2'b01,
    QM_X2  = 2'b10,
    QM_X4  = 2'b11
  } qmode_e;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_FWD,
    STEP_REV,
    STEP_BAD
  } step_e;

  // Gray pair {b,a} to a position 0..3 along the forward order
  function automatic logic [1:0] phase_pos(input logic b, input logic a);
    return {b, b ^ a};
  endfunction

  function automatic step_e classify(input logic [1:0] prev_pos, input logic [1:0] cur_pos);
    logic [1:0] delta;
    delta = cur_pos - prev_pos;
    case (delta)
      2'd0:    return STEP_NONE;
      2'd1:    return STEP_FWD;
      2'd3:    return STEP_REV;
      default: return STEP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/qdec_rst_sync.sv
module qdec_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/qdec_sync2.sv
module qdec_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;

endmodule

// File: rtl/qdec_stab_filter.sv
module qdec_stab_filter #(
  parameter int unsigned STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          level_q, level_d;
  logic [CW-1:0] run_q, run_d;
  logic          differ;
  logic          upd_en;

  always_comb begin
    differ  = din ^ level_q;
    level_d = level_q;
    run_d   = '0;
    if (differ) begin
      if (run_q == LAST) begin
        level_d = din;
        run_d   = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
    upd_en = differ || (run_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (upd_en) begin
      level_q <= level_d;
      run_q   <= run_d;
    end
  end

  assign dout = level_q;

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   b_is_dir,
  input  logic   gate_n,
  input  logic   in_a,
  input  logic   in_b,
  output logic   up_stb,
  output logic   dn_stb,
  output logic   dir_up
);

  logic  prev_a_q, prev_b_q;
  logic  up_q, dn_q, dir_q;
  logic  up_d, dn_d, dir_d;
  logic  want_up, want_dn;
  logic  quad;
  logic  a_moved, a_rise, b_rise, x1_edge;
  step_e st;

  always_comb begin
    quad    = (mode != QM_OFF);
    st      = classify(phase_pos(prev_b_q, prev_a_q), phase_pos(in_b, in_a));
    a_moved = in_a ^ prev_a_q;
    a_rise  = in_a & ~prev_a_q;
    b_rise  = in_b & ~prev_b_q;
    x1_edge = a_moved & ~in_b & ~prev_b_q;
    want_up = 1'b0;
    want_dn = 1'b0;
    case (mode)
      QM_X4: begin
        want_up = (st == STEP_FWD);
        want_dn = (st == STEP_REV);
      end
      QM_X2: begin
        want_up = (st == STEP_FWD) & a_moved;
        want_dn = (st == STEP_REV) & a_moved;
      end
      QM_X1: begin
        want_up = (st == STEP_FWD) & x1_edge;
        want_dn = (st == STEP_REV) & x1_edge;
      end
      default: begin
        if (b_is_dir) begin
          want_up = a_rise & ~in_b;
          want_dn = a_rise & in_b;
        end else begin
          want_up = a_rise & ~b_rise;
          want_dn = b_rise & ~a_rise;
        end
      end
    endcase
    up_d  = want_up & gate_n;
    dn_d  = want_dn & gate_n;
    dir_d = dir_q;
    if (quad && up_d) dir_d = 1'b1;
    else if (quad && dn_d) dir_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      dir_q    <= 1'b1;
    end else begin
      prev_a_q <= in_a;
      prev_b_q <= in_b;
      up_q     <= up_d;
      dn_q     <= dn_d;
      dir_q    <= dir_d;
    end
  end

  assign up_stb = up_q;
  assign dn_stb = dn_q;
  assign dir_up = quad ? dir_q : 1'b1;

endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       b_is_dir,
  input  logic       gate_n,
  input  logic       enc_a,
  input  logic       enc_b,
  output logic       up_stb,
  output logic       dn_stb,
  output logic       dir_up
);

  localparam int unsigned NCH = 2;

  logic           rst_core_n;
  logic [NCH-1:0] raw_ph;
  logic [NCH-1:0] sync_ph;
  logic [NCH-1:0] filt_ph;
  logic [NCH-1:0] sel_ph;
  qmode_e         mode_e;

  assign raw_ph = {enc_b, enc_a};
  assign mode_e = qmode_e'(mode);

  qdec_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  qdec_sync2 #(.WIDTH(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (raw_ph),
    .dout  (sync_ph)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
    qdec_stab_filter #(.STABLE_CYC(FILT_CYCLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_core_n),
      .din   (sync_ph[ch]),
      .dout  (filt_ph[ch])
    );
  end

  assign sel_ph = (mode_e == QM_OFF) ? sync_ph : filt_ph;

  qdec_step_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .mode     (mode_e),
    .b_is_dir (b_is_dir),
    .gate_n   (gate_n),
    .in_a     (sel_ph[0]),
    .in_b     (sel_ph[1]),
    .up_stb   (up_stb),
    .dn_stb   (dn_stb),
    .dir_up   (dir_up)
  );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       gate_n,
  input logic       up_stb,
  input logic       dn_stb,
  input logic       dir_up
);

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_stb && dn_stb)); // R13

  AST_DIR_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> dir_up); // R9

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_n) |-> !(up_stb || dn_stb)); // R12

  AST_DIR_WITH_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_stb && mode != 2'b00) |-> dir_up); // R8

  AST_DIR_WITH_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stb && mode != 2'b00) |-> !dir_up); // R8

endmodule

bind qdec_top qdec_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (mode),
  .gate_n (gate_n),
  .up_stb (up_stb),
  .dn_stb (dn_stb),
  .dir_up (dir_up)
);

// File: tb/tb_qdec_top.sv
module tb_qdec_top;

  localparam int unsigned FILT = 4;
  localparam int NVEC = 29;

  // [7:6] mode, [5] b_is_dir, [4] b, [3] a, [2] up, [1] dn, [0] dir
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11001101, 8'b11011101, 8'b11010101, 8'b11000101, 8'b11010010,
    8'b11011010, 8'b11000000,
    8'b10001101, 8'b10011001, 8'b10010101, 8'b10000001, 8'b10010001,
    8'b10011010,
    8'b01001000, 8'b01000010, 8'b01001101, 8'b01011001, 8'b01010001,
    8'b01000001,
    8'b00001101, 8'b00000001, 8'b00010011, 8'b00000001,
    8'b00101101, 8'b00100001, 8'b00110001, 8'b00111011, 8'b00110001,
    8'b00100001
  };

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       b_is_dir;
  logic       gate_n;
  logic       enc_a;
  logic       enc_b;
  logic       up_stb;
  logic       dn_stb;
  logic       dir_up;

  int n_checks = 0;
  int n_fail   = 0;
  int up_cnt   = 0;
  int dn_cnt   = 0;
  int overlap  = 0;
  bit done     = 0;

  qdec_top #(.FILT_CYCLES(FILT)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .b_is_dir (b_is_dir),
    .gate_n   (gate_n),
    .enc_a    (enc_a),
    .enc_b    (enc_b),
    .up_stb   (up_stb),
    .dn_stb   (dn_stb),
    .dir_up   (dir_up)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (up_stb) up_cnt++;
      if (dn_stb) dn_cnt++;
      if (up_stb && dn_stb) overlap++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (FILT + 10) @(negedge clk);
  endtask

  function automatic string row_tag(input int i);
    if (i == 6)  return "R5";
    if (i < 7)   return "R2/R8";
    if (i < 13)  return "R3/R8";
    if (i < 19)  return "R4/R8";
    if (i < 23)  return "R10/R9";
    return "R11/R9";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int u0, d0;
    rst_n = 1'b0; mode = 2'b11; b_is_dir = 1'b0; gate_n = 1'b1;
    enc_a = 1'b0; enc_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(up_stb == 1'b0 && dn_stb == 1'b0, "R1 strobes in reset", {up_stb, dn_stb}, 0);
    check(dir_up == 1'b1, "R1 dir in reset", dir_up, 1);
    rst_n = 1'b1;
    settle();
    check(up_cnt == 0 && dn_cnt == 0 && dir_up, "R1 idle after reset", up_cnt + dn_cnt, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      u0 = up_cnt; d0 = dn_cnt;
      mode = VEC[i][7:6]; b_is_dir = VEC[i][5];
      enc_b = VEC[i][4]; enc_a = VEC[i][3];
      settle();
      check((up_cnt - u0) == int'(VEC[i][2]) && (dn_cnt - d0) == int'(VEC[i][1]),
            $sformatf("%s row %0d up/dn", row_tag(i), i),
            (up_cnt - u0) * 10 + (dn_cnt - d0), int'(VEC[i][2]) * 10 + int'(VEC[i][1]));
      check(dir_up == VEC[i][0], $sformatf("%s row %0d dir", row_tag(i), i),
            dir_up, VEC[i][0]);
    end

    // R7: quadrature latency, x4 from settled 00
    mode = 2'b11; b_is_dir = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
    settle();
    enc_a = 1'b1;
    repeat (FILT + 2) @(posedge clk);
    @(negedge clk);
    check(up_stb == 1'b0, "R7 quad strobe not early", up_stb, 0);
    @(posedge clk);
    @(negedge clk);
    check(up_stb == 1'b1, "R7 quad strobe on time", up_stb, 1);
    enc_a = 1'b0;
    settle();

    // R7: non-quadrature latency
    mode = 2'b00;
    settle();
    enc_a = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(up_stb == 1'b0, "R7 plain strobe not early", up_stb, 0);
    @(posedge clk);
    @(negedge clk);
    check(up_stb == 1'b1, "R7 plain strobe on time", up_stb, 1);
    enc_a = 1'b0;
    settle();

    // R12: gate blocks and gated motion is not counted later
    mode = 2'b11;
    settle();
    u0 = up_cnt; d0 = dn_cnt;
    gate_n = 1'b0;
    enc_a = 1'b1;
    settle();
    check(up_cnt == u0 && dn_cnt == d0, "R12 gated step", up_cnt - u0, 0);
    gate_n = 1'b1;
    settle();
    check(up_cnt == u0 && dn_cnt == d0, "R12 no count on release", up_cnt - u0, 0);
    enc_b = 1'b1;
    settle();
    check(up_cnt == u0 + 1 && dn_cnt == d0, "R12 counts after release", up_cnt - u0, 1);

    // R6: glitch one clock short of the filter is ignored (state {B,A}=11)
    u0 = up_cnt; d0 = dn_cnt;
    enc_a = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    enc_a = 1'b1;
    settle();
    check(up_cnt == u0 && dn_cnt == d0, "R6 short glitch", (up_cnt - u0) + (dn_cnt - d0), 0);

    // R6: excursion of exactly FILT clocks is accepted both ways
    enc_a = 1'b0;
    repeat (FILT) @(negedge clk);
    enc_a = 1'b1;
    settle();
    check(up_cnt == u0 + 1 && dn_cnt == d0 + 1, "R6 exact-length excursion",
          (up_cnt - u0) * 10 + (dn_cnt - d0), 11);

    // R13: strobes never overlapped during the run
    check(overlap == 0, "R13 strobe overlap", overlap, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule